// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares the timing of two digital inputs, a reference signal and a feedback (comparator) signal, and produces the steering for a charge-type loop-filter driver. The driver has three modes: source (pull-up), sink (pull-down) or released (high impedance). A source request means the feedback must speed up. A sink request means it must slow down. A released output holds the filter voltage. A separate lock output is high whenever the driver is released, so it marks cycles in which the two inputs are aligned.

Both inputs are asynchronous to the system clock. Each passes through a flop synchroniser (`SYNC_STAGES` deep, default 2). A one-cycle rising-edge detector follows it. Only rising edges reach the detector state machine, which has three states:
- `PFD_HOLD`: released.
- `PFD_UP`: sourcing.
- `PFD_DN`: sinking.

The transitions are:
- `T_SIG_LEAD`: from HOLD to UP on a signal edge.
- `T_CMP_LEAD`: from HOLD to DN on a comparator edge.
- `T_UP_CLEAR`: from UP to HOLD on a comparator edge.
- `T_DN_CLEAR`: from DN to HOLD on a signal edge.
- `T_STAY`: UP on a further signal edge, DN on a further comparator edge, or any state when both edges arrive in one cycle.
- `T_RESET`: any state to HOLD.

Top module: `pfd_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters HOLD and clears its synchroniser and edge history. After that edge `pull_up_o`=0, `pull_dn_o`=0, `drive_en_o`=0 and `lock_o`=1.
- R2: A rising input edge placed between clock edges first acts on the outputs right after the third rising clock edge that follows it (SYNC_STAGES+1 with the default). The outputs are unchanged after the second edge.
- R3: In HOLD, a signal rising edge alone moves the block to UP: `pull_up_o`=1, `drive_en_o`=1, `lock_o`=0.
- R4: In HOLD, a comparator rising edge alone moves the block to DN: `pull_dn_o`=1, `drive_en_o`=1, `lock_o`=0.
- R5: Mutual reset. In UP, a comparator edge returns the block to HOLD. In DN, a signal edge returns the block to HOLD.
- R6: A repeated edge of the leading input keeps the state. In particular, comparator edges with no signal activity keep `pull_dn_o`=1 continuously.
- R7: Rising edges on both inputs recognised in the same cycle leave the state unchanged.
- R8: Falling edges and levels have no effect. An input that falls, or stays high, changes no output.
- R9: `pull_up_o` and `pull_dn_o` are never high together. `drive_en_o` equals `pull_up_o | pull_dn_o`, and `lock_o` equals its inverse.
- R10: With the signal toggling faster than the comparator, `pull_up_o` is high in more cycles than `pull_dn_o`. With the signal slower, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Reference signal input, asynchronous |
| cmp_in | input | 1 | Feedback (comparator) input, asynchronous |
| pull_up_o | output | 1 | Source-driver enable |
| pull_dn_o | output | 1 | Sink-driver enable |
| drive_en_o | output | 1 | Driver enable. Low means high impedance |
| lock_o | output | 1 | Phase-pulse lock indicator, high when released |

## Verification
A wrong state register shows at the ports in the same cycle, because all four outputs decode the state directly. A missed mutual reset shows as a driver held on past the lagging edge. A stuck synchroniser or edge detector shows up as a late reaction or a missing one. This is visible exactly three clock edges after the stimulus, so the bench compares every output in every cycle against its own model. An extra or lost edge leaves a lasting state offset, which stays visible until the next opposite edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PFD_HOLD = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2
    } pfd_state_e;

    localparam int PFD_NCH = 2;
    localparam int PFD_CH_SIG = 0;
    localparam int PFD_CH_CMP = 1;

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];

    initial begin
        assert_depth_R2: assert (STAGES >= 2)
            else $error("synchroniser needs at least two stages");
    end
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    // A detected edge lasts exactly one cycle
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

    // Falling level never reports an edge
    assert_no_fall_edge_R8: assert property (@(posedge clk) disable iff (rst)
        !level_i |-> !rise_o);
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_rise_i,
    input  logic cmp_rise_i,
    output logic pull_up_o,
    output logic pull_dn_o,
    output logic drive_en_o,
    output logic lock_o
);
    pfd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFD_HOLD: begin
                if (sig_rise_i && !cmp_rise_i)      state_d = PFD_UP;   // T_SIG_LEAD
                else if (cmp_rise_i && !sig_rise_i) state_d = PFD_DN;   // T_CMP_LEAD
            end
            PFD_UP: begin
                if (cmp_rise_i && !sig_rise_i)      state_d = PFD_HOLD; // T_UP_CLEAR
            end
            PFD_DN: begin
                if (sig_rise_i && !cmp_rise_i)      state_d = PFD_HOLD; // T_DN_CLEAR
            end
            default:                                state_d = PFD_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PFD_HOLD;                                   // T_RESET
        else     state_q <= state_d;
    end

    always_comb begin
        pull_up_o  = 1'b0;
        pull_dn_o  = 1'b0;
        drive_en_o = 1'b0;
        lock_o     = 1'b1;
        unique case (state_q)
            PFD_HOLD: ;
            PFD_UP: begin
                pull_up_o  = 1'b1;
                drive_en_o = 1'b1;
                lock_o     = 1'b0;
            end
            PFD_DN: begin
                pull_dn_o  = 1'b1;
                drive_en_o = 1'b1;
                lock_o     = 1'b0;
            end
            default: ;
        endcase
    end

    assert_reset_hold_R1: assert property (@(posedge clk)
        rst |=> (lock_o && !drive_en_o));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(pull_up_o && pull_dn_o));

    assert_enable_R9: assert property (@(posedge clk) disable iff (rst)
        drive_en_o == (pull_up_o | pull_dn_o));

    assert_lock_R9: assert property (@(posedge clk) disable iff (rst)
        lock_o != drive_en_o);

    assert_up_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (pull_up_o && cmp_rise_i && !sig_rise_i) |=> lock_o);

    assert_dn_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (pull_dn_o && sig_rise_i && !cmp_rise_i) |=> lock_o);

    assert_both_edges_R7: assert property (@(posedge clk) disable iff (rst)
        (sig_rise_i && cmp_rise_i) |=> ($stable(pull_up_o) && $stable(pull_dn_o)));

    assert_hold_start_R3: assert property (@(posedge clk) disable iff (rst)
        (lock_o && sig_rise_i && !cmp_rise_i) |=> pull_up_o);

    assert_hold_start_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_o && cmp_rise_i && !sig_rise_i) |=> pull_dn_o);

    assert_dn_stays_R6: assert property (@(posedge clk) disable iff (rst)
        (pull_dn_o && !sig_rise_i) |=> pull_dn_o);
endmodule

// File: rtl/pfd_top.sv
module pfd_top
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic cmp_in,
    output logic pull_up_o,
    output logic pull_dn_o,
    output logic drive_en_o,
    output logic lock_o
);
    logic [PFD_NCH-1:0] raw_in;
    logic [PFD_NCH-1:0] synced;
    logic [PFD_NCH-1:0] rise;

    assign raw_in[PFD_CH_SIG] = sig_in;
    assign raw_in[PFD_CH_CMP] = cmp_in;

    generate
        for (genvar ch = 0; ch < PFD_NCH; ch++) begin : g_chan
            pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d_i (raw_in[ch]),
                .q_o (synced[ch])
            );
            pfd_edge u_edge (
                .clk     (clk),
                .rst     (rst),
                .level_i (synced[ch]),
                .rise_o  (rise[ch])
            );
        end
    endgenerate

    pfd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sig_rise_i (rise[PFD_CH_SIG]),
        .cmp_rise_i (rise[PFD_CH_CMP]),
        .pull_up_o  (pull_up_o),
        .pull_dn_o  (pull_dn_o),
        .drive_en_o (drive_en_o),
        .lock_o     (lock_o)
    );
endmodule

// File: tb/pfd_top_tb_top.sv
module pfd_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic cmp_in = 1'b0;
    logic pull_up_o, pull_dn_o, drive_en_o, lock_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfd_top dut_i (
        .clk(clk), .rst(rst), .sig_in(sig_in), .cmp_in(cmp_in),
        .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o),
        .drive_en_o(drive_en_o), .lock_o(lock_o)
    );

    // Requirement model: 0 hold, 1 up, 2 dn; edges seen 3 clock edges late
    logic a1, a2, a3, b1, b2, b3;
    int   m_st;

    always @(posedge clk) begin
        if (rst) begin
            a1 <= 0; a2 <= 0; a3 <= 0; b1 <= 0; b2 <= 0; b3 <= 0;
            m_st <= 0;
        end else begin
            a1 <= sig_in; a2 <= a1; a3 <= a2;
            b1 <= cmp_in; b2 <= b1; b3 <= b2;
            m_st <= next_st(m_st, a2 & ~a3, b2 & ~b3);
        end
    end

    function automatic int next_st(int st, logic s, logic c);
        if (s && c) return st;
        if (st == 0 && s) return 1;
        if (st == 0 && c) return 2;
        if (st == 1 && c) return 0;
        if (st == 2 && s) return 0;
        return st;
    endfunction

    function automatic logic [3:0] outs_of(int st);
        // {pull_up, pull_dn, drive_en, lock}
        case (st)
            1:       return 4'b1010;
            2:       return 4'b0110;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic check(string req, logic [3:0] exp);
        logic [3:0] act;
        act = {pull_up_o, pull_dn_o, drive_en_o, lock_o};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int up_cnt, dn_cnt;
        logic [31:0] r;
        r = $urandom(32'd20240);
        tick(); tick();
        rst = 1'b0;
        check("R1 reset state", 4'b0001);

        // R2 latency and R3 hold->up
        sig_in = 1'b1;
        tick(); check("R2 no change after edge 1", 4'b0001);
        tick(); check("R2 no change after edge 2", 4'b0001);
        tick(); check("R3 up after edge 3", 4'b1010);
        // R8 falling edge and high level ignored
        sig_in = 1'b0;
        repeat (6) tick();
        check("R8 falling sig ignored", 4'b1010);
        // R6 repeated sig edge keeps up
        sig_in = 1'b1; repeat (5) tick();
        check("R6 up stays on second sig edge", 4'b1010);
        // R5 up cleared by cmp edge
        cmp_in = 1'b1; repeat (3) tick();
        check("R5 up cleared by cmp", 4'b0001);
        // R8 high levels stay: nothing changes
        repeat (8) tick();
        check("R8 high levels ignored", 4'b0001);

        // R4 hold->dn
        sig_in = 1'b0; cmp_in = 1'b0; repeat (4) tick();
        cmp_in = 1'b1; repeat (3) tick();
        check("R4 dn after cmp edge", 4'b0110);
        // R5 dn cleared by sig edge
        sig_in = 1'b1; repeat (3) tick();
        check("R5 dn cleared by sig", 4'b0001);

        // R7 simultaneous edges
        sig_in = 1'b0; cmp_in = 1'b0; repeat (4) tick();
        sig_in = 1'b1; cmp_in = 1'b1; repeat (4) tick();
        check("R7 simultaneous from hold", 4'b0001);

        // R1 reset from UP
        sig_in = 1'b0; cmp_in = 1'b0; repeat (4) tick();
        sig_in = 1'b1; repeat (3) tick();
        check("R3 up before reset", 4'b1010);
        do_reset();
        check("R1 reset clears up", 4'b0001);

        // R6 comparator only: pull-down held continuously
        do_reset();
        sig_in = 1'b0; cmp_in = 1'b0;
        repeat (3) tick();
        for (int i = 0; i < 200; i++) begin
            if (i % 4 == 0) cmp_in = ~cmp_in;
            tick();
            if (i >= 8) check("R6 no signal keeps pull-down", 4'b0110);
        end

        // R10 signal faster
        do_reset();
        sig_in = 0; cmp_in = 0; up_cnt = 0; dn_cnt = 0;
        for (int i = 0; i < 600; i++) begin
            if (i % 3 == 0) sig_in = ~sig_in;
            if (i % 5 == 0) cmp_in = ~cmp_in;
            tick();
            check("R9 fast sig vs model", outs_of(m_st));
            up_cnt += pull_up_o; dn_cnt += pull_dn_o;
        end
        total++;
        if (!(up_cnt > dn_cnt)) begin
            bad++;
            $display("FAIL R10 fast sig actual up=%0d dn=%0d expected up>dn", up_cnt, dn_cnt);
        end

        // R10 signal slower
        do_reset();
        sig_in = 0; cmp_in = 0; up_cnt = 0; dn_cnt = 0;
        for (int i = 0; i < 600; i++) begin
            if (i % 7 == 0) sig_in = ~sig_in;
            if (i % 4 == 0) cmp_in = ~cmp_in;
            tick();
            check("R9 slow sig vs model", outs_of(m_st));
            up_cnt += pull_up_o; dn_cnt += pull_dn_o;
        end
        total++;
        if (!(dn_cnt > up_cnt)) begin
            bad++;
            $display("FAIL R10 slow sig actual up=%0d dn=%0d expected dn>up", up_cnt, dn_cnt);
        end

        // Random toggling, including duty changes and coincident edges
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            if (r[2:0] == 3'd0) sig_in = ~sig_in;
            if (r[5:3] == 3'd0) cmp_in = ~cmp_in;
            if (r[9:6] == 4'd0) begin sig_in = ~sig_in; cmp_in = ~cmp_in; end
            if (r[19:10] == 10'd0) begin
                rst = 1'b1; tick(); rst = 1'b0;
                check("R1 random reset", 4'b0001);
            end else begin
                tick();
                check("R8 random vs model", outs_of(m_st));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule